// File: doc/BRIEF.md
# Reversed Nibble Sample Readout

This block drains a capture memory in which every byte packs two 4-bit logic samples and turns it into a stream of one sample per byte for a host link. The host that receives the burst shows it back to front, so the block sends the most recent sample first and ends with the oldest one. The net result is that the host displays the capture in time order.

A one-cycle start pulse arms a burst and latches a requested sample count. The block then reads the memory through a read port with one cycle of latency, starting at the highest used byte and counting down. It splits each byte into two zero-extended samples and offers them on a valid/ready stream. After the host accepts the last sample, a one-cycle done pulse marks the end of the burst.

Top module: `nibble_readout`

## Requirements
- R1: After reset, out_valid_o, done_o and mem_rd_o are all low, and they stay low until a start pulse arrives.
- R2: Every output sample carries one 4-bit nibble of a stored byte in out_data_o[3:0], and out_data_o[7:4] is zero.
- R3: With N samples there are B = ceil(N/2) bytes. Bytes are read in the order B-1, B-2, ..., 0, one read per byte, so the most recent sample is sent first.
- R4: For a byte whose two nibbles are both sent, bits [3:0] are sent first and bits [7:4] follow. The low nibble holds the later capture position.
- R5: When N is odd, the byte at address B-1 yields only its bits [3:0], as the first sample. Every byte below it yields both nibbles.
- R6: A sample count of 0 selects the default burst of 512 samples. A count above the memory capacity (2 samples per address) is clamped to that capacity.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged in the next cycle.
- R8: Exactly N samples are handed over. done_o is high for exactly one cycle, in the cycle right after the last accepted sample, and out_valid_o is low from then until the next burst.
- R9: A start pulse that arrives while a burst is running, including in the cycle of the final handshake, is ignored. No further burst follows.
- R10: The byte returned on mem_data_i in the cycle after mem_rd_o is the one that gets split. No sample is offered in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that arms a burst |
| sample_count_i | input | 10 | Requested sample count (0 selects the default) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 8 | Memory byte address |
| mem_data_i | input | 8 | Read data, valid one cycle after the strobe |
| out_data_o | output | 8 | Zero-extended sample |
| out_valid_o | output | 1 | Sample valid |
| out_ready_i | input | 1 | Host ready |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
Two functions can land on the same clock edge: a new start request and the final handshake of a burst, which also triggers the done pulse. The bench raises start_i at the very edge where the last sample is accepted. It judges the result by three things: the done pulse lasts exactly one cycle, the sample total stays as requested, and no valid sample or memory read appears in the cycles that follow. Backpressure patterns are also applied while a byte is half consumed, to check that the held sample cannot slip across the high/low nibble boundary.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_LO,
        ST_HI,
        ST_FIN
    } nrd_state_e;

endpackage

// File: rtl/nrd_len_calc.sv
module nrd_len_calc #(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = ADDR_W + 2,
    parameter int DEF_SAMPLES = 512
) (
    input  logic [CNT_W-1:0]  raw_cnt_i,
    output logic [CNT_W-1:0]  eff_cnt_o,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic              odd_o
);
    localparam int CAP = 2 ** (ADDR_W + 1);
    localparam int DEF_CLAMP = (DEF_SAMPLES > CAP) ? CAP : DEF_SAMPLES;
    localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] DEF_C = CNT_W'(DEF_CLAMP);

    logic [CNT_W-1:0] minus_one;

    always_comb begin
        if (raw_cnt_i == '0) begin
            eff_cnt_o = DEF_C;
        end else if (raw_cnt_i > CAP_C) begin
            eff_cnt_o = CAP_C;
        end else begin
            eff_cnt_o = raw_cnt_i;
        end
        minus_one  = eff_cnt_o - CNT_W'(1);
        top_addr_o = ADDR_W'(minus_one >> 1);
        odd_o      = eff_cnt_o[0];
    end

endmodule

// File: rtl/nrd_nibble_mux.sv
module nrd_nibble_mux #(
    parameter int NIB_W = 4,
    parameter int OUT_W = 8
) (
    input  logic [2*NIB_W-1:0] byte_i,
    input  logic               sel_hi_i,
    output logic [OUT_W-1:0]   sample_o
);
    logic [NIB_W-1:0] nib;

    always_comb begin
        nib = sel_hi_i ? byte_i[2*NIB_W-1:NIB_W] : byte_i[NIB_W-1:0];
    end

    generate
        if (OUT_W > NIB_W) begin : g_ext
            assign sample_o = {{(OUT_W-NIB_W){1'b0}}, nib};
        end else begin : g_trunc
            assign sample_o = nib[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/nrd_ctrl.sv
module nrd_ctrl
    import nrd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = ADDR_W + 2,
    parameter int MEM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  eff_cnt_i,
    input  logic [ADDR_W-1:0] top_addr_i,
    input  logic              odd_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [MEM_W-1:0]  mem_data_i,
    output logic [MEM_W-1:0]  byte_o,
    output logic              sel_hi_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic              done_o
);
    typedef struct packed {
        nrd_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic              skip_hi;
        logic [MEM_W-1:0]  data;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  last_take;

    always_comb begin
        r_d       = r_q;
        last_take = (r_q.left == CNT_W'(1));
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.addr    = top_addr_i;
                    r_d.left    = eff_cnt_i;
                    r_d.skip_hi = odd_i;
                    r_d.state   = ST_FETCH;
                end
            end
            ST_FETCH: r_d.state = ST_LOAD;
            ST_LOAD: begin
                r_d.data  = mem_data_i;
                r_d.state = ST_LO;
            end
            ST_LO: begin
                if (out_ready_i) begin
                    r_d.left = r_q.left - CNT_W'(1);
                    if (last_take) begin
                        r_d.state = ST_FIN;
                    end else if (r_q.skip_hi) begin
                        r_d.skip_hi = 1'b0;
                        r_d.addr    = r_q.addr - ADDR_W'(1);
                        r_d.state   = ST_FETCH;
                    end else begin
                        r_d.state = ST_HI;
                    end
                end
            end
            ST_HI: begin
                if (out_ready_i) begin
                    r_d.left = r_q.left - CNT_W'(1);
                    if (last_take) begin
                        r_d.state = ST_FIN;
                    end else begin
                        r_d.addr  = r_q.addr - ADDR_W'(1);
                        r_d.state = ST_FETCH;
                    end
                end
            end
            ST_FIN:  r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.addr    <= '0;
            r_q.left    <= '0;
            r_q.skip_hi <= 1'b0;
            r_q.data    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_o    = (r_q.state == ST_FETCH);
    assign mem_addr_o  = r_q.addr;
    assign byte_o      = r_q.data;
    assign sel_hi_o    = (r_q.state == ST_HI);
    assign out_valid_o = (r_q.state == ST_LO) || (r_q.state == ST_HI);
    assign done_o      = (r_q.state == ST_FIN);

    // Checker state: last read address within the running burst.
    logic              chk_prev_q;
    logic [ADDR_W-1:0] chk_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || r_q.state == ST_IDLE) begin
            chk_prev_q <= 1'b0;
            chk_addr_q <= '0;
        end else if (mem_rd_o) begin
            chk_prev_q <= 1'b1;
            chk_addr_q <= mem_addr_o;
        end
    end

    // R3: each read in a burst sits one address below the previous one.
    a_r3_addr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && chk_prev_q) |-> (mem_addr_o == chk_addr_q - ADDR_W'(1)));

    // R10: the cycle after a read only captures data; nothing is offered.
    a_r10_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !out_valid_o);

    // R8: done lasts one cycle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done follows an accepted sample.
    a_r8_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(out_valid_o && out_ready_i));

endmodule

// File: rtl/nibble_readout.sv
module nibble_readout #(
    parameter int ADDR_W      = 8,
    parameter int NIB_W       = 4,
    parameter int OUT_W       = 8,
    parameter int CNT_W       = ADDR_W + 2,
    parameter int DEF_SAMPLES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  sample_count_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [2*NIB_W-1:0] mem_data_i,
    output logic [OUT_W-1:0]  out_data_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic              done_o
);
    localparam int MEM_W = 2 * NIB_W;

    logic [CNT_W-1:0]  eff_cnt;
    logic [ADDR_W-1:0] top_addr;
    logic              odd;
    logic [MEM_W-1:0]  cur_byte;
    logic              sel_hi;

    nrd_len_calc #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .DEF_SAMPLES (DEF_SAMPLES)
    ) u_len (
        .raw_cnt_i  (sample_count_i),
        .eff_cnt_o  (eff_cnt),
        .top_addr_o (top_addr),
        .odd_o      (odd)
    );

    nrd_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .MEM_W  (MEM_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .eff_cnt_i   (eff_cnt),
        .top_addr_i  (top_addr),
        .odd_i       (odd),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_i  (mem_data_i),
        .byte_o      (cur_byte),
        .sel_hi_o    (sel_hi),
        .out_valid_o (out_valid_o),
        .out_ready_i (out_ready_i),
        .done_o      (done_o)
    );

    nrd_nibble_mux #(
        .NIB_W (NIB_W),
        .OUT_W (OUT_W)
    ) u_mux (
        .byte_i   (cur_byte),
        .sel_hi_i (sel_hi),
        .sample_o (out_data_o)
    );

    // R7: a stalled sample is held unchanged.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R2: upper bits of every offered sample are zero.
    a_r2_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_data_o[OUT_W-1:NIB_W] == '0));

    // R1: no activity right after reset until a start pulse.
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !start_i) |=> !mem_rd_o);

endmodule

// File: tb/nibble_readout_bench.sv
module nibble_readout_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] count = '0;
    logic       mem_rd;
    logic [7:0] mem_addr;
    logic [7:0] mem_q = '0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       ready = 1'b0;
    logic       done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    nibble_readout u_nibble_readout (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .sample_count_i (count),
        .mem_rd_o       (mem_rd),
        .mem_addr_o     (mem_addr),
        .mem_data_i     (mem_q),
        .out_data_o     (out_data),
        .out_valid_o    (out_valid),
        .out_ready_i    (ready),
        .done_o         (done)
    );

    always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expv(input int n, input int i);
        int  b = (n + 1) / 2;
        int  by;
        bit  hi;
        if (n % 2 == 1) begin
            if (i == 0) begin by = b - 1; hi = 1'b0; end
            else begin by = b - 2 - (i - 1) / 2; hi = ((i - 1) % 2) == 1; end
        end else begin
            by = b - 1 - i / 2;
            hi = (i % 2) == 1;
        end
        return hi ? {4'h0, mem[by][7:4]} : {4'h0, mem[by][3:0]};
    endfunction

    task automatic run_burst(input int raw, input int n, input int mode, input bit poke);
        int   got = 0;
        int   rd_idx = 0;
        int   cyc = 0;
        bit   fin = 1'b0;
        bit   stall = 1'b0;
        logic [7:0] held = '0;
        int   b = (n + 1) / 2;
        string tag;
        @(negedge clk);
        count = 10'(raw);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 5000) begin
            case (mode)
                0: ready = 1'b1;
                1: ready = cyc[0];
                default: ready = (cyc % 3) != 0;
            endcase
            if (mem_rd) begin
                check(mem_addr == 8'(b - 1 - rd_idx), "R3 read address", mem_addr, b - 1 - rd_idx);
                rd_idx++;
            end
            if (stall)
                check(out_valid && out_data == held, "R7 hold", out_data, held);
            if (done) begin
                check(got == n, "R8 sample total", got, n);
                check(rd_idx == b, "R3 read total", rd_idx, b);
                fin = 1'b1;
            end else if (out_valid && ready) begin
                if (n % 2 == 1 && got == 0) tag = "R5 odd head";
                else if (got % 2 != n % 2) tag = "R4 high nibble";
                else tag = "R3 reverse order";
                check(out_data == expv(n, got), tag, out_data, expv(n, got));
                check(out_data[7:4] == 4'h0, "R2 zero ext", out_data[7:4], 0);
                got++;
                if (poke && got == n) start = 1'b1;
            end
            stall = out_valid && !ready;
            held  = out_data;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        if (!fin) check(1'b0, "R8 done seen", 0, 1);
        check(!done, "R8 done width", done, 0);
        for (int k = 0; k < 4; k++) begin
            check(!out_valid && !mem_rd, "R9 no new burst", out_valid, 0);
            @(negedge clk);
        end
        ready = 1'b0;
    endtask

    localparam int NV = 7;
    localparam int V_RAW  [NV] = '{1, 2, 5, 8, 0, 700, 3};
    localparam int V_N    [NV] = '{1, 2, 5, 8, 512, 512, 3};
    localparam int V_MODE [NV] = '{0, 1, 2, 2, 1, 0, 1};

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'((k * 37 + 91) ^ (k >> 3));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!out_valid && !done && !mem_rd, "R1 reset quiet", out_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && !done && !mem_rd, "R1 idle quiet", mem_rd, 0);

        // Vector table: R6 covered by raw 0 and raw 700 rows.
        for (int v = 0; v < NV; v++)
            run_burst(V_RAW[v], V_N[v], V_MODE[v], 1'b0);

        // R9: start raised in the cycle of the final handshake.
        run_burst(4, 4, 0, 1'b1);
        run_burst(7, 7, 2, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule